// File: doc/BRIEF.md
# Event-to-Interrupt Aggregator

This block gathers a wide vector of single-cycle system event pulses and folds them onto a small number of virtual interrupt lines. Each event owns a map entry. The entry names a target virtual interrupt and a bit slot inside that interrupt's 64-bit pending word. Up to 64 sources can therefore share one interrupt line while each stays separately visible and clearable.

The host controls the block over a simple word-addressed register bus. Reads return data in the same cycle. Through this bus the host reads pending words, clears pending bits with write-one-to-clear, and sets or clears enable bits. The map entries sit on the same bus, but a write to them only takes effect when the privilege flag is high during the write.

An event whose map entry is not valid is discarded. A saturating counter records how many events were discarded.

Top module: `evagg_top`

## Requirements
- R1: After reset every pending bit and every enable bit is zero, every map entry reads 0, the drop counter reads 0 and every `irq_o` bit is low.
- R2: An event pulse on `evt_i[e]`, sampled at a clock edge, sets pending bit b of virtual interrupt v at that edge, where (v, b) come from map entry e. Pending bits 31..0 read at word address v*8+0 and bits 63..32 at v*8+1.
- R3: Events that arrive in the same cycle are all recorded, including several events that target different bits of the same virtual interrupt.
- R4: `irq_o[v]` is high exactly while the pending word of v ANDed with its enable word is non-zero.
- R5: Writing ones to a pending half clears those pending bits at the write edge. When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: Writing ones to address v*8+2 (low half) or v*8+3 (high half) sets enable bits. Writing ones to v*8+4 or v*8+5 clears them. All four addresses read back the current enable half.
- R7: A write to map entry e (address 0x400+e) takes effect only when `bus_priv` is 1. With `bus_priv` at 0 the entry keeps its old value.
- R8: An event whose map entry is invalid, or whose entry names a virtual interrupt index at or above the interrupt count, sets no pending bit. Each such event adds one to the drop counter at address 0xC00, which saturates at its all-ones value (255 by default).
- R9: The map entry format is: bit 31 = valid, bits 21:16 = bit slot, bits 6:0 = virtual interrupt index. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT | Event pulses, one bit per global event |
| bus_wr | input | 1 | Register write strobe |
| bus_priv | input | 1 | Privilege flag for map writes |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_o | output | NUM_VINT | Level virtual interrupt outputs |

## Verification
A corrupted map entry makes an event land in the wrong pending word. A lost entry makes the event vanish into the drop counter. Either fault shows on the next pending read after the edge that samples the event. A stuck or lost pending or enable bit shows within one cycle, either on `irq_o` or when its half-word is read back. The bench reads every such word directly after the cycle that should change it. Because the set-over-clear priority is checked in the same cycle as the conflicting write, a reversed priority is caught at once.

// File: rtl/evagg_pkg.sv
package evagg_pkg;

    localparam int PEND_W = 64;
    localparam int HALF_W = 32;
    localparam int SLOT_W = 6;
    localparam int VIDX_W = 7;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        RGN_VINT = 2'b00,
        RGN_MAP  = 2'b01,
        RGN_RSV  = 2'b10,
        RGN_DROP = 2'b11
    } region_e;

    typedef enum logic [2:0] {
        SEL_PEND_LO = 3'd0,
        SEL_PEND_HI = 3'd1,
        SEL_ENS_LO  = 3'd2,
        SEL_ENS_HI  = 3'd3,
        SEL_ENC_LO  = 3'd4,
        SEL_ENC_HI  = 3'd5,
        SEL_RSV6    = 3'd6,
        SEL_RSV7    = 3'd7
    } vsel_e;

    typedef struct packed {
        logic              valid;
        logic [VIDX_W-1:0] vint;
        logic [SLOT_W-1:0] slot;
    } map_ent_t;

    function automatic logic [BUS_W-1:0] map_pack(input map_ent_t m);
        logic [BUS_W-1:0] w;
        w        = '0;
        w[31]    = m.valid;
        w[21:16] = m.slot;
        w[6:0]   = m.vint;
        return w;
    endfunction

    function automatic map_ent_t map_unpack(input logic [BUS_W-1:0] w);
        map_ent_t m;
        m.valid = w[31];
        m.slot  = w[21:16];
        m.vint  = w[6:0];
        return m;
    endfunction

    function automatic logic [PEND_W-1:0] half_place(input logic hi, input logic [HALF_W-1:0] d);
        return hi ? {d, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, d};
    endfunction

endpackage

// File: rtl/evagg_map_table.sv
module evagg_map_table
    import evagg_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  logic                     priv_i,
    input  logic [9:0]               idx_i,
    input  logic [BUS_W-1:0]         wdata_i,
    output map_ent_t [NUM_EVT-1:0]   tbl_o
);

    map_ent_t [NUM_EVT-1:0] tbl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else if (wr_i && priv_i) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                if (idx_i == 10'(e)) tbl_q[e] <= map_unpack(wdata_i);
            end
        end
    end

    assign tbl_o = tbl_q;

    AST_MAP_PRIV_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && priv_i) |=> $stable(tbl_q)); // R7

endmodule

// File: rtl/evagg_router.sv
module evagg_router
    import evagg_pkg::*;
#(
    parameter int NUM_EVT  = 16,
    parameter int NUM_VINT = 4,
    parameter int DROP_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_EVT-1:0]                  evt_i,
    input  map_ent_t [NUM_EVT-1:0]              tbl_i,
    output logic [NUM_VINT-1:0][PEND_W-1:0]     set_o,
    output logic [DROP_W-1:0]                   drop_o
);

    localparam int CNT_W = $clog2(NUM_EVT + 1);
    localparam int SUM_W = DROP_W + CNT_W + 1;
    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    logic [CNT_W-1:0]  ndrop;
    logic [SUM_W-1:0]  sum;
    logic [DROP_W-1:0] drop_q, drop_d;

    always_comb begin
        set_o = '0;
        ndrop = '0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (evt_i[e]) begin
                if (tbl_i[e].valid && (32'(tbl_i[e].vint) < NUM_VINT)) begin
                    for (int v = 0; v < NUM_VINT; v++) begin
                        if (tbl_i[e].vint == VIDX_W'(v)) set_o[v][tbl_i[e].slot] = 1'b1;
                    end
                end else begin
                    ndrop = ndrop + CNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        sum = SUM_W'(drop_q) + SUM_W'(ndrop);
        if (sum > SUM_W'(DROP_MAX)) drop_d = DROP_MAX;
        else                        drop_d = sum[DROP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) drop_q <= '0;
        else     drop_q <= drop_d;
    end

    assign drop_o = drop_q;

    AST_DROP_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (drop_q >= $past(drop_q))); // R8
    AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (drop_q == DROP_MAX) |=> (drop_q == DROP_MAX)); // R8

endmodule

// File: rtl/evagg_vint_status.sv
module evagg_vint_status
    import evagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PEND_W-1:0] set_i,
    input  logic [PEND_W-1:0] clr_i,
    input  logic [PEND_W-1:0] ens_i,
    input  logic [PEND_W-1:0] enc_i,
    output logic [PEND_W-1:0] pend_o,
    output logic [PEND_W-1:0] en_o,
    output logic              irq_o
);

    logic [PEND_W-1:0] pend_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
            en_q   <= (en_q | ens_i) & ~enc_i;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = |(pend_q & en_q);

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((pend_q & $past(clr_i) & ~$past(set_i)) == '0)); // R5
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (($past(set_i) != '0) || ($past(ens_i) != '0))); // R4
    AST_IRQ_OFF_NO_EN: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o); // R4

endmodule

// File: rtl/evagg_top.sv
module evagg_top
    import evagg_pkg::*;
#(
    parameter int NUM_EVT  = 16,
    parameter int NUM_VINT = 4,
    parameter int DROP_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EVT-1:0]   evt_i,
    input  logic                 bus_wr,
    input  logic                 bus_priv,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [NUM_VINT-1:0]  irq_o
);

    region_e               region;
    vsel_e                 vsel;
    logic [VIDX_W-1:0]     vidx;
    logic [9:0]            eidx;

    map_ent_t [NUM_EVT-1:0]             tbl;
    logic [NUM_VINT-1:0][PEND_W-1:0]    set_v, clr_v, ens_v, enc_v, pend_v, en_v;
    logic [DROP_W-1:0]                  drop_cnt;
    logic                               map_wr;

    assign region = region_e'(bus_addr[11:10]);
    assign vsel   = vsel_e'(bus_addr[2:0]);
    assign vidx   = bus_addr[9:3];
    assign eidx   = bus_addr[9:0];
    assign map_wr = bus_wr && (region == RGN_MAP);

    always_comb begin
        clr_v = '0;
        ens_v = '0;
        enc_v = '0;
        if (bus_wr && region == RGN_VINT) begin
            for (int v = 0; v < NUM_VINT; v++) begin
                if (vidx == VIDX_W'(v)) begin
                    case (vsel)
                        SEL_PEND_LO: clr_v[v] = half_place(1'b0, bus_wdata);
                        SEL_PEND_HI: clr_v[v] = half_place(1'b1, bus_wdata);
                        SEL_ENS_LO:  ens_v[v] = half_place(1'b0, bus_wdata);
                        SEL_ENS_HI:  ens_v[v] = half_place(1'b1, bus_wdata);
                        SEL_ENC_LO:  enc_v[v] = half_place(1'b0, bus_wdata);
                        SEL_ENC_HI:  enc_v[v] = half_place(1'b1, bus_wdata);
                        default: ;
                    endcase
                end
            end
        end
    end

    evagg_map_table #(.NUM_EVT(NUM_EVT)) u_map (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (map_wr),
        .priv_i  (bus_priv),
        .idx_i   (eidx),
        .wdata_i (bus_wdata),
        .tbl_o   (tbl)
    );

    evagg_router #(.NUM_EVT(NUM_EVT), .NUM_VINT(NUM_VINT), .DROP_W(DROP_W)) u_route (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .tbl_i  (tbl),
        .set_o  (set_v),
        .drop_o (drop_cnt)
    );

    for (genvar v = 0; v < NUM_VINT; v++) begin : g_vint
        evagg_vint_status u_stat (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[v]),
            .clr_i  (clr_v[v]),
            .ens_i  (ens_v[v]),
            .enc_i  (enc_v[v]),
            .pend_o (pend_v[v]),
            .en_o   (en_v[v]),
            .irq_o  (irq_o[v])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (region)
            RGN_VINT: begin
                for (int v = 0; v < NUM_VINT; v++) begin
                    if (vidx == VIDX_W'(v)) begin
                        case (vsel)
                            SEL_PEND_LO:            bus_rdata = pend_v[v][HALF_W-1:0];
                            SEL_PEND_HI:            bus_rdata = pend_v[v][PEND_W-1:HALF_W];
                            SEL_ENS_LO, SEL_ENC_LO: bus_rdata = en_v[v][HALF_W-1:0];
                            SEL_ENS_HI, SEL_ENC_HI: bus_rdata = en_v[v][PEND_W-1:HALF_W];
                            default:                bus_rdata = '0;
                        endcase
                    end
                end
            end
            RGN_MAP: begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (eidx == 10'(e)) bus_rdata = map_pack(tbl[e]);
                end
            end
            RGN_DROP: bus_rdata = BUS_W'(drop_cnt);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/evagg_top_test.sv
module evagg_top_test;
    import evagg_pkg::*;

    localparam int NE = 16;
    localparam int NV = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NE-1:0]     evt_i = '0;
    logic              bus_wr = 1'b0;
    logic              bus_priv = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic [NV-1:0]     irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        int          vint;
        string       tag;
    } item_t;

    item_t q[$];

    always #4 clk = ~clk;

    evagg_top #(.NUM_EVT(NE), .NUM_VINT(NV), .DROP_W(8)) uut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_irq ? 32'(irq_o[it.vint]) : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic fire(input logic [NE-1:0] m);
        @(posedge clk); #1;
        evt_i = m;
        @(posedge clk); #1;
        evt_i = '0;
    endtask

    task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 0; it.exp = e; it.vint = 0; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    task automatic exp_irq(input int v, input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1; it.exp = 32'(e); it.vint = v; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        exp_rd(12'h000, 32'h0, "R1 pend v0 lo");
        exp_rd(12'h012, 32'h0, "R1 enable v2 lo");
        exp_rd(12'h400, 32'h0, "R1 map e0");
        exp_rd(12'hC00, 32'h0, "R1 drop counter");
        exp_irq(2, 1'b0, "R1 irq2");

        wr(12'h400, 32'h8005_0002, 1'b0);
        exp_rd(12'h400, 32'h0, "R7 unprivileged map write ignored");
        fire(16'h0001);
        exp_rd(12'hC00, 32'd1, "R8 invalid entry dropped");
        exp_rd(12'h010, 32'h0, "R8 no pending from dropped event");

        wr(12'h400, 32'h8005_0002, 1'b1);
        wr(12'h401, 32'h8028_0002, 1'b1);
        wr(12'h402, 32'h803F_0002, 1'b1);
        wr(12'h403, 32'h8000_0000, 1'b1);
        exp_rd(12'h400, 32'h8005_0002, "R9 map format readback");
        exp_rd(12'h401, 32'h8028_0002, "R9 map e1 readback");

        fire(16'h0001);
        exp_rd(12'h010, 32'h0000_0020, "R2 e0 -> v2 bit5");
        exp_irq(2, 1'b0, "R4 irq2 low while disabled");

        fire(16'h000E);
        exp_rd(12'h011, 32'h8000_0100, "R3 e1,e2 same vint high half");
        exp_rd(12'h000, 32'h0000_0001, "R3 e3 -> v0 bit0");
        exp_rd(12'h010, 32'h0000_0020, "R3 earlier bit kept");

        wr(12'h012, 32'h0000_0020, 1'b0);
        exp_rd(12'h012, 32'h0000_0020, "R6 enable set lo");
        exp_irq(2, 1'b1, "R4 irq2 high once enabled");

        wr(12'h010, 32'h0000_0020, 1'b0);
        exp_rd(12'h010, 32'h0, "R5 W1C clears pending");
        exp_irq(2, 1'b0, "R4 irq2 low after clear");

        wr(12'h013, 32'hFFFF_FFFF, 1'b0);
        wr(12'h015, 32'h7FFF_FFFF, 1'b0);
        exp_rd(12'h015, 32'h8000_0000, "R6 enable clear hi");
        exp_irq(2, 1'b1, "R4 irq2 via bit63");
        exp_irq(0, 1'b0, "R4 irq0 pending but disabled");

        @(posedge clk); #1;
        evt_i = 16'h0001; bus_wr = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0000_0020;
        @(posedge clk); #1;
        evt_i = '0; bus_wr = 1'b0;
        exp_rd(12'h010, 32'h0000_0020, "R5 set wins over same-cycle clear");

        wr(12'h403, 32'h8005_0002, 1'b0);
        exp_rd(12'h403, 32'h8000_0000, "R7 host write keeps entry");
        fire(16'h0008);
        exp_rd(12'h010, 32'h0000_0020, "R7 e3 not rerouted to v2");

        fire(16'hFFF0);
        exp_rd(12'hC00, 32'd13, "R8 multiple drops in one cycle");
        for (int i = 0; i < 24; i++) fire(16'hFFF0);
        exp_rd(12'hC00, 32'd255, "R8 drop counter saturates");

        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule